// File: doc/BRIEF.md
# Indirect Subbank Register Window

This block gives a host access to fifteen 16-bit serial-port control registers through only two host addresses. The lower of the two (the window base) holds a subaddress pointer. The address just above it is a data port. A host read or write at the data port reaches whichever internal register the pointer currently names. The block stores all fifteen registers. It presents their contents as one flat output vector, so downstream serial-port logic can use every field directly.

The host bus is plain and single-cycle: address, write data, a write strobe and a read strobe. Every access is accepted in the cycle it is presented, with no back-pressure. A write lands on the clock edge that ends the strobed cycle. Read data is valid combinationally in the strobed cycle. When the block is not being read, its read data is zero, so several instances at different bases can have their read buses ORed together.

Top module: `sbk_regwin`

## Requirements
- R1: A synchronous active-high reset clears the pointer and all fifteen registers to 0000h.
- R2: A write at the base address loads the full 16-bit pointer on that clock edge. A read at the base address returns the pointer value in the same cycle.
- R3: A write at base+1 with a pointer value k in 0..14 updates only register k. Register k appears on `cfg_flat[16*k+15:16*k]`. The subaddresses, in order, are: control 1, control 2, receive control 1/2, transmit control 1/2, rate generator 1/2, multichannel 1/2, receive enable A/B, transmit enable A/B, and pin control (14).
- R4: A read at base+1 with a pointer value of 0..14 returns the selected register in the same cycle. Data written in an earlier cycle is visible.
- R5: When the pointer is 15 (0Fh) or more, a read at base+1 returns 0000h and a write at base+1 changes no register.
- R6: Reads and writes at base+1 leave the pointer unchanged; there is no auto-increment.
- R7: Writes to any address other than base and base+1 change neither the pointer nor any register. Reads at such addresses return 0000h.
- R8: While the read strobe is low, the read data is 0000h, whatever the address.
- R9: Two instances with different bases on a shared bus respond only to their own two addresses and keep separate state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W (8) | Host address |
| host_wdata | input | DATA_W (16) | Host write data |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | DATA_W (16) | Read data, zero when this window is not read |
| cfg_flat | output | NUM_REGS*DATA_W (240) | All registers, register k in slice k |

## Verification
The bench applies several access patterns:
- A sweep that writes distinct values into every subaddress, then reads each one back. This separates correct slice ordering from swapped or aliased registers.
- Pointer values just above the last register (0Fh) and at FFFFh. These show whether out-of-range decoding is full-width or truncated.
- Back-to-back data accesses with no pointer write between them. Any auto-increment shows up here.
- Traffic to neighbouring addresses, and to a second instance at another base. This shows that decoding is exact.
- A mid-run reset from non-zero contents.
- A read with the strobe low, which exposes read data that leaks when the block is not selected.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
  localparam int SBK_DATA_W   = 16;
  localparam int SBK_ADDR_W   = 8;
  localparam int SBK_NUM_REGS = 15;

  // Subaddress order seen by downstream serial-port logic
  typedef enum logic [3:0] {
    SA_CTL1   = 4'd0,
    SA_CTL2   = 4'd1,
    SA_RXCTL1 = 4'd2,
    SA_RXCTL2 = 4'd3,
    SA_TXCTL1 = 4'd4,
    SA_TXCTL2 = 4'd5,
    SA_RATE1  = 4'd6,
    SA_RATE2  = 4'd7,
    SA_MCH1   = 4'd8,
    SA_MCH2   = 4'd9,
    SA_RXENA  = 4'd10,
    SA_RXENB  = 4'd11,
    SA_TXENA  = 4'd12,
    SA_TXENB  = 4'd13,
    SA_PINCTL = 4'd14
  } sbk_sub_e;
endpackage

// File: rtl/sbk_decode.sv
module sbk_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              ptr_wr,
  output logic              ptr_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  localparam logic [ADDR_W-1:0] PTR_ADDR = BASE;
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE + 1'b1;

  logic hit_ptr, hit_dat;

  always_comb begin
    hit_ptr = (addr == PTR_ADDR);
    hit_dat = (addr == DAT_ADDR);
    ptr_wr  = wr && hit_ptr;
    ptr_rd  = rd && hit_ptr;
    dat_wr  = wr && hit_dat;
    dat_rd  = rd && hit_dat;
  end
endmodule

// File: rtl/sbk_regbank.sv
module sbk_regbank #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          sel,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] flat,
  output logic [DATA_W-1:0]          rd_val
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [DATA_W-1:0] MY_SEL = DATA_W'(k);
    logic hit;
    assign hit = wr_en && (sel == MY_SEL);

    always_ff @(posedge clk) begin
      if (rst)      regs[k] <= '0;
      else if (hit) regs[k] <= wdata;
    end

    assign flat[k*DATA_W +: DATA_W] = regs[k];
  end

  // Selected register; out-of-range selectors fall through to zero
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (sel == DATA_W'(k)) rd_val = regs[k];
    end
  end
endmodule

// File: rtl/sbk_regwin.sv
module sbk_regwin
  import sbk_pkg::*;
#(
  parameter int ADDR_W   = SBK_ADDR_W,
  parameter int DATA_W   = SBK_DATA_W,
  parameter int NUM_REGS = SBK_NUM_REGS,
  parameter logic [ADDR_W-1:0] BASE = 8'h39
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [DATA_W-1:0]          host_wdata,
  input  logic                       host_wr,
  input  logic                       host_rd,
  output logic [DATA_W-1:0]          host_rdata,
  output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);
  logic              ptr_wr, ptr_rd, dat_wr, dat_rd;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] sel_val;

  sbk_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr   (host_addr),
    .wr     (host_wr),
    .rd     (host_rd),
    .ptr_wr (ptr_wr),
    .ptr_rd (ptr_rd),
    .dat_wr (dat_wr),
    .dat_rd (dat_rd)
  );

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (ptr_wr) ptr_q <= host_wdata;
  end

  sbk_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (dat_wr),
    .sel    (ptr_q),
    .wdata  (host_wdata),
    .flat   (cfg_flat),
    .rd_val (sel_val)
  );

  always_comb begin
    if (ptr_rd)      host_rdata = ptr_q;
    else if (dat_rd) host_rdata = sel_val;
    else             host_rdata = '0;
  end
endmodule

// File: rtl/sbk_regwin_chk.sv
module sbk_regwin_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 15,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          host_addr,
  input logic [DATA_W-1:0]          host_wdata,
  input logic                       host_wr,
  input logic                       host_rd,
  input logic [DATA_W-1:0]          host_rdata,
  input logic [NUM_REGS*DATA_W-1:0] cfg_flat,
  input logic [DATA_W-1:0]          ptr_q
);
  localparam logic [ADDR_W-1:0] A_PTR = BASE;
  localparam logic [ADDR_W-1:0] A_DAT = BASE + 1'b1;
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(NUM_REGS);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ptr_q == '0) && (cfg_flat == '0)); // R1

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_PTR) |=> ptr_q == $past(host_wdata)); // R2

  AST_REGS_HELD: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_addr == A_DAT && ptr_q < LIMIT) |=> $stable(cfg_flat)); // R5

  AST_NO_AUTOINC: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_addr == A_PTR) |=> $stable(ptr_q)); // R6

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_DAT && ptr_q >= LIMIT) |-> host_rdata == '0); // R5

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !host_rd |-> host_rdata == '0); // R8

  AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_addr != A_PTR && host_addr != A_DAT) |-> host_rdata == '0); // R7
endmodule

bind sbk_regwin sbk_regwin_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE(BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .cfg_flat   (cfg_flat),
  .ptr_q      (ptr_q)
);

// File: tb/tb_sbk_regwin.sv
`timescale 1ns/1ps
module tb_sbk_regwin;
  localparam int NR = 15;
  localparam logic [7:0] BASE_A = 8'h39;
  localparam logic [7:0] BASE_B = 8'h49;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic        wr = 0, rd = 0;
  logic [15:0] rdata_a, rdata_b;
  logic [NR*16-1:0] flat_a, flat_b;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  sbk_regwin #(.BASE(BASE_A)) dut (
    .clk(clk), .rst(rst), .host_addr(addr), .host_wdata(wdata),
    .host_wr(wr), .host_rd(rd), .host_rdata(rdata_a), .cfg_flat(flat_a));

  sbk_regwin #(.BASE(BASE_B)) dut_b (
    .clk(clk), .rst(rst), .host_addr(addr), .host_wdata(wdata),
    .host_wr(wr), .host_rd(rd), .host_rdata(rdata_b), .cfg_flat(flat_b));

  // Behavioural reference: two windows, each a pointer plus a register array
  logic [15:0] m_ptr [2];
  logic [15:0] m_reg [2][NR];
  logic [7:0]  m_base [2];
  initial begin
    m_base[0] = BASE_A;
    m_base[1] = BASE_B;
  end

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_ptr[i] = 0;
        for (int k = 0; k < NR; k++) m_reg[i][k] = 0;
      end else if (wr) begin
        if (addr == m_base[i]) m_ptr[i] = wdata;
        else if (addr == m_base[i] + 8'd1 && m_ptr[i] < 16'(NR))
          m_reg[i][m_ptr[i][3:0]] = wdata;
      end
    end
  end

  function automatic logic [15:0] exp_rd(int i);
    if (!rd) return 16'h0;
    if (addr == m_base[i]) return m_ptr[i];
    if (addr == m_base[i] + 8'd1)
      return (m_ptr[i] < 16'(NR)) ? m_reg[i][m_ptr[i][3:0]] : 16'h0;
    return 16'h0;
  endfunction

  function automatic logic [NR*16-1:0] exp_flat(int i);
    logic [NR*16-1:0] v;
    for (int k = 0; k < NR; k++) v[k*16 +: 16] = m_reg[i][k];
    return v;
  endfunction

  task automatic chk16(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk16("rdata_a", rdata_a, exp_rd(0));
      chk16("rdata_b", rdata_b, exp_rd(1));
      checks++;
      if (flat_a !== exp_flat(0) || flat_b !== exp_flat(1)) begin
        failures++;
        $display("FAIL %s cfg_flat actual=%h/%h expected=%h/%h", cur_req,
                 flat_a, flat_b, exp_flat(0), exp_flat(1));
      end
    end
  end

  task automatic bus(logic [7:0] a, logic [15:0] d, logic w, logic r);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = w; rd = r;
  endtask

  task automatic idle();
    bus(8'h00, 16'h0, 0, 0);
  endtask

  // Directed check with a literal expectation, sampled mid-cycle
  task automatic rd_expect(logic [7:0] a, logic [15:0] exp, string what);
    bus(a, 16'h0, 0, 1);
    #1;
    chk16(what, (a >= BASE_B) ? rdata_b : rdata_a, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    chk16("reset flat", flat_a[15:0] | flat_a[NR*16-1 -: 16], 16'h0);
    rst = 0;
    rd_expect(BASE_A, 16'h0, "reset pointer");

    cur_req = "R2";
    bus(BASE_A, 16'h0005, 1, 0);
    rd_expect(BASE_A, 16'h0005, "pointer readback");

    cur_req = "R3";
    for (int k = 0; k < NR; k++) begin
      bus(BASE_A, 16'(k), 1, 0);
      bus(BASE_A + 8'd1, 16'hA000 + 16'(k * 16'h0111), 1, 0);
    end
    idle();
    #1;
    chk16("pin control slice 14", flat_a[14*16 +: 16], 16'hA000 + 16'(14 * 16'h0111));
    chk16("control 1 slice 0", flat_a[15:0], 16'hA000);

    cur_req = "R4";
    for (int k = NR - 1; k >= 0; k--) begin
      bus(BASE_A, 16'(k), 1, 0);
      rd_expect(BASE_A + 8'd1, 16'hA000 + 16'(k * 16'h0111), "data readback");
    end
    bus(BASE_A, 16'd3, 1, 0);
    bus(BASE_A + 8'd1, 16'h1234, 1, 1);
    rd_expect(BASE_A + 8'd1, 16'h1234, "write then read");

    cur_req = "R5";
    bus(BASE_A, 16'h000F, 1, 0);
    bus(BASE_A + 8'd1, 16'hDEAD, 1, 0);
    rd_expect(BASE_A + 8'd1, 16'h0, "pointer 0Fh read");
    bus(BASE_A, 16'hFFFF, 1, 0);
    bus(BASE_A + 8'd1, 16'hBEEF, 1, 0);
    rd_expect(BASE_A + 8'd1, 16'h0, "pointer FFFFh read");
    bus(BASE_A, 16'h0010, 1, 0);
    bus(BASE_A + 8'd1, 16'h5555, 1, 0);
    bus(BASE_A, 16'd0, 1, 0);
    rd_expect(BASE_A + 8'd1, 16'hA000, "reg 0 untouched by 10h alias");

    cur_req = "R6";
    bus(BASE_A, 16'd7, 1, 0);
    bus(BASE_A + 8'd1, 16'h0707, 1, 0);
    bus(BASE_A + 8'd1, 16'h7070, 1, 0);
    rd_expect(BASE_A + 8'd1, 16'h7070, "no auto-increment data");
    rd_expect(BASE_A, 16'd7, "pointer unchanged");

    cur_req = "R7";
    bus(BASE_A - 8'd1, 16'hFFFF, 1, 0);
    bus(BASE_A + 8'd2, 16'hFFFF, 1, 0);
    rd_expect(BASE_A + 8'd2, 16'h0, "foreign read");
    rd_expect(BASE_A, 16'd7, "pointer after foreign writes");
    rd_expect(BASE_A + 8'd1, 16'h7070, "register after foreign writes");

    cur_req = "R8";
    bus(BASE_A + 8'd1, 16'h0, 0, 0);
    #1;
    chk16("strobe low", rdata_a, 16'h0);

    cur_req = "R9";
    bus(BASE_B, 16'd7, 1, 0);
    bus(BASE_B + 8'd1, 16'h9999, 1, 0);
    rd_expect(BASE_B + 8'd1, 16'h9999, "second instance data");
    rd_expect(BASE_A + 8'd1, 16'h7070, "first instance unaffected");

    cur_req = "R1";
    @(posedge clk); #1;
    rst = 1; wr = 0; rd = 0;
    @(posedge clk); #1;
    rst = 0;
    #1;
    chk16("mid-run reset slice 7", flat_a[7*16 +: 16], 16'h0);
    rd_expect(BASE_B, 16'h0, "second pointer after reset");
    idle();
    repeat (2) @(posedge clk);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule